// File: doc/BRIEF.md
# MII Management Status Poller

This block watches the link of an external PHY without any help from software. While it is enabled and the PHY is marked present, it sends IEEE 802.3 clause 22 read frames on MDC/MDIO one after another, with a programmable idle gap between them. It latches the 16-bit word that the PHY returns. A port-selection controller downstream uses two outputs. The first is a one-cycle pulse that fires whenever a new word differs from the one held before it. The second is a level that goes high when the link bit of the held word is clear.

By default each poll reads the PHY status register (register 1). A select input can point the poll at another register address instead. The gap is chosen with a 3-bit code. The code is sampled at the end of each frame, and its step sizes are powers of two up to 2048 MDC periods. Dropping the enable or the presence input stops new frames. A frame that has already started always runs to its last bit.

Top module: `mdio_autopoll`

## Requirements
- R1: After reset, mdc is 0, mdio_o is 1, mdio_oe is 0, and frame_busy, status_valid, status_changed and link_down are all 0.
- R2: mdc runs freely with a high phase and a low phase of MDC_HALF clock cycles each, so one MDC period is 2*MDC_HALF clock cycles.
- R3: Each frame is 64 MDC periods long and is sent most significant bit first. Bits 0..31 are 1 (preamble). Bits 32..35 are 0,1,1,0 (start and read opcode). Bits 36..40 are phy_addr[4:0] and bits 41..45 are the register address [4:0]. mdio_o changes only on a falling edge of mdc, and it idles at 1.
- R4: mdio_oe is 1 during frame bits 0..45. It is 0 during the turnaround bits 46..47, during the data bits 48..63, and whenever frame_busy is 0.
- R5: The register address field carries 1 when use_alt_reg is 0, and alt_reg_addr when use_alt_reg is 1. Both inputs are sampled when a frame starts.
- R6: mdio_i is sampled on the rising mdc edge of bits 48..63, most significant bit first. The 16 bits appear on status_word, with status_valid set to 1, before frame_busy falls.
- R7: frame_busy stays low between two frames for exactly (G+1) MDC periods. G is 0 for a gap_sel of 0 and 2^(gap_sel+4) otherwise, so a gap_sel of 7 gives G = 2048. gap_sel is sampled when a frame ends.
- R8: status_changed is a single-cycle pulse. It fires when a captured word differs from the word held before it. It does not fire on the first capture after reset, and it does not fire when the new word is equal to the held word.
- R9: link_down is 1 exactly when status_valid is 1 and bit 2 of status_word is 0.
- R10: A frame starts only while both poll_en and phy_present are 1. If either is 0, no frame starts.
- R11: If poll_en or phy_present is cleared while a frame is in progress, that frame still completes all 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| poll_en | input | 1 | Enables autonomous polling |
| phy_present | input | 1 | External PHY present and active |
| phy_addr | input | 5 | PHY address placed in every frame |
| gap_sel | input | 3 | Idle gap code between frames |
| use_alt_reg | input | 1 | 1 selects alt_reg_addr instead of register 1 |
| alt_reg_addr | input | 5 | Alternate register address |
| mdio_i | input | 1 | MDIO input from the pad |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| frame_busy | output | 1 | High while a frame is on the wire |
| status_word | output | 16 | Last captured PHY register word |
| status_valid | output | 1 | At least one word has been captured |
| status_changed | output | 1 | One-cycle pulse on a changed word |
| link_down | output | 1 | Held word reports the link as down |

## Verification
The hardest case to reach is a poll being cut off partway through a frame. The bench waits for frame_busy to rise, lets about ten MDC periods go by, and then drops poll_en so that the clear lands inside the preamble. It then counts the rising mdc edges until frame_busy falls. A behavioural PHY in the bench answers each frame by driving mdio_i after every falling edge in the data phase, taking the bits from a word the bench controls. This is how equal words, changed words and link-down words are produced across back-to-back polls.

// File: rtl/mdio_autopoll_pkg.sv
package mdio_autopoll_pkg;

    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int HDR_BITS   = 14;
    localparam int TA_FIRST   = PRE_BITS + HDR_BITS;
    localparam int DATA_FIRST = TA_FIRST + 2;
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 5;
    localparam int IDX_W      = $clog2(FRAME_BITS) + 1;
    localparam int GAP_SEL_W  = 3;
    localparam int GAP_CNT_W  = (2 ** GAP_SEL_W - 1) + 5;

    localparam logic [ADDR_W-1:0] STATUS_REG = 5'd1;

    typedef struct packed {
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
    } poll_target_t;

    typedef enum logic [1:0] {
        PH_PREAMBLE,
        PH_HEADER,
        PH_RELEASE
    } bit_phase_e;

    function automatic bit_phase_e phase_of(input logic [IDX_W-1:0] idx);
        if (int'(idx) < PRE_BITS)
            return PH_PREAMBLE;
        else if (int'(idx) < TA_FIRST)
            return PH_HEADER;
        return PH_RELEASE;
    endfunction

    function automatic logic [HDR_BITS-1:0] header_of(input poll_target_t t);
        return {2'b01, 2'b10, t.phy, t.regad};
    endfunction

    function automatic logic [GAP_CNT_W-1:0] gap_periods(input logic [GAP_SEL_W-1:0] sel);
        int unsigned sh;
        sh = int'(sel) + 4;
        if (sel == '0)
            return '0;
        return GAP_CNT_W'(1) << sh;
    endfunction

endpackage

// File: rtl/mdio_clock_gen.sv
module mdio_clock_gen #(
    parameter int HALF_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap      = (cnt == LAST);
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/poll_gap_timer.sv
module poll_gap_timer
    import mdio_autopoll_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic                 fall_tick,
    input  logic                 busy,
    input  logic                 frame_end,
    input  logic [GAP_SEL_W-1:0] gap_sel,
    output logic                 start_ok
);
    logic [GAP_CNT_W-1:0] remain;

    assign start_ok = run && (remain == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (frame_end) begin
            remain <= gap_periods(gap_sel);
        end else if (!run) begin
            remain <= '0;
        end else if (fall_tick && !busy && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
    import mdio_autopoll_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              start_ok,
    input  poll_target_t      target,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              busy,
    output logic              frame_end,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_word
);
    localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] DATA_IDX   = IDX_W'(DATA_FIRST);

    logic [IDX_W-1:0]    bit_idx;
    logic [IDX_W-1:0]    next_idx;
    logic [HDR_BITS-1:0] hdr_sr;
    logic [DATA_W-1:0]   data_sr;

    assign next_idx  = bit_idx + 1'b1;
    assign frame_end = fall_tick && busy && (bit_idx == LAST_IDX);
    assign rd_word   = data_sr;

    // drive side: every transition happens on the falling MDC edge
    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            bit_idx <= '0;
            hdr_sr  <= '0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
        end else if (fall_tick) begin
            if (!busy) begin
                if (start_ok) begin
                    busy    <= 1'b1;
                    bit_idx <= '0;
                    hdr_sr  <= header_of(target);
                    mdio_o  <= 1'b1;
                    mdio_oe <= 1'b1;
                end
            end else if (bit_idx == LAST_IDX) begin
                busy    <= 1'b0;
                mdio_o  <= 1'b1;
                mdio_oe <= 1'b0;
            end else begin
                bit_idx <= next_idx;
                unique case (phase_of(next_idx))
                    PH_PREAMBLE: begin
                        mdio_o  <= 1'b1;
                        mdio_oe <= 1'b1;
                    end
                    PH_HEADER: begin
                        mdio_o  <= hdr_sr[HDR_BITS-1];
                        mdio_oe <= 1'b1;
                        hdr_sr  <= {hdr_sr[HDR_BITS-2:0], 1'b0};
                    end
                    default: begin
                        mdio_o  <= 1'b1;
                        mdio_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

    // sample side: data bits captured on the rising MDC edge
    always_ff @(posedge clk) begin
        if (rst) begin
            data_sr <= '0;
            rd_done <= 1'b0;
        end else begin
            rd_done <= 1'b0;
            if (rise_tick && busy && bit_idx >= DATA_IDX) begin
                data_sr <= {data_sr[DATA_W-2:0], mdio_i};
                if (bit_idx == LAST_IDX)
                    rd_done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/poll_status_track.sv
module poll_status_track
    import mdio_autopoll_pkg::*;
#(
    parameter int LINK_BIT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] status_word,
    output logic              status_valid,
    output logic              status_changed,
    output logic              link_down
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status_word    <= '0;
            status_valid   <= 1'b0;
            status_changed <= 1'b0;
            link_down      <= 1'b0;
        end else begin
            status_changed <= 1'b0;
            if (rd_done) begin
                status_word    <= rd_word;
                status_valid   <= 1'b1;
                status_changed <= status_valid && (rd_word != status_word);
                link_down      <= !rd_word[LINK_BIT];
            end
        end
    end
endmodule

// File: rtl/mdio_autopoll.sv
module mdio_autopoll
    import mdio_autopoll_pkg::*;
#(
    parameter int MDC_HALF = 2,
    parameter int LINK_BIT = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 poll_en,
    input  logic                 phy_present,
    input  logic [ADDR_W-1:0]    phy_addr,
    input  logic [GAP_SEL_W-1:0] gap_sel,
    input  logic                 use_alt_reg,
    input  logic [ADDR_W-1:0]    alt_reg_addr,
    input  logic                 mdio_i,
    output logic                 mdc,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic                 frame_busy,
    output logic [DATA_W-1:0]    status_word,
    output logic                 status_valid,
    output logic                 status_changed,
    output logic                 link_down
);
    logic              rise_tick, fall_tick;
    logic              run, start_ok, frame_end, rd_done;
    logic [DATA_W-1:0] rd_word;
    poll_target_t      target;

    assign run          = poll_en && phy_present;
    assign target.phy   = phy_addr;
    assign target.regad = use_alt_reg ? alt_reg_addr : STATUS_REG;

    mdio_clock_gen #(.HALF_CYCLES(MDC_HALF)) u_clk (
        .clk       (clk),
        .rst       (rst),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    poll_gap_timer u_gap (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .fall_tick (fall_tick),
        .busy      (frame_busy),
        .frame_end (frame_end),
        .gap_sel   (gap_sel),
        .start_ok  (start_ok)
    );

    mdio_frame_shifter u_frm (
        .clk       (clk),
        .rst       (rst),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .start_ok  (start_ok),
        .target    (target),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .busy      (frame_busy),
        .frame_end (frame_end),
        .rd_done   (rd_done),
        .rd_word   (rd_word)
    );

    poll_status_track #(.LINK_BIT(LINK_BIT)) u_trk (
        .clk            (clk),
        .rst            (rst),
        .rd_done        (rd_done),
        .rd_word        (rd_word),
        .status_word    (status_word),
        .status_valid   (status_valid),
        .status_changed (status_changed),
        .link_down      (link_down)
    );
endmodule

// File: rtl/mdio_autopoll_chk.sv
module mdio_autopoll_chk (
    input logic        clk,
    input logic        rst,
    input logic        poll_en,
    input logic        phy_present,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        frame_busy,
    input logic [15:0] status_word,
    input logic        status_valid,
    input logic        status_changed
);
    logic       mdc_d;
    logic [6:0] rises_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            mdc_d      <= 1'b0;
            rises_seen <= '0;
        end else begin
            mdc_d <= mdc;
            if (!frame_busy)
                rises_seen <= '0;
            else if (mdc && !mdc_d)
                rises_seen <= rises_seen + 1'b1;
        end
    end

    p_oe_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !frame_busy |-> !mdio_oe);

    p_mdio_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        (mdio_o != $past(mdio_o)) |-> (!mdc && $past(mdc)));

    p_start_gated_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_busy) |-> $past(poll_en && phy_present));

    p_full_frame_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(frame_busy) |-> (rises_seen == 7'd64));

    p_change_real_r8: assert property (@(posedge clk) disable iff (rst)
        status_changed |-> (status_valid && status_word != $past(status_word)));

    p_change_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        status_changed |=> !status_changed);
endmodule

bind mdio_autopoll mdio_autopoll_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .poll_en        (poll_en),
    .phy_present    (phy_present),
    .mdc            (mdc),
    .mdio_o         (mdio_o),
    .mdio_oe        (mdio_oe),
    .frame_busy     (frame_busy),
    .status_word    (status_word),
    .status_valid   (status_valid),
    .status_changed (status_changed)
);

// File: tb/tb_mdio_autopoll.sv
`timescale 1ns/1ps
module tb_mdio_autopoll;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        poll_en = 1'b0;
    logic        phy_present = 1'b1;
    logic [4:0]  phy_addr = 5'h13;
    logic [2:0]  gap_sel = 3'd0;
    logic        use_alt_reg = 1'b0;
    logic [4:0]  alt_reg_addr = 5'h00;
    logic        mdio_i = 1'b1;
    logic        mdc, mdio_o, mdio_oe, frame_busy;
    logic [15:0] status_word;
    logic        status_valid, status_changed, link_down;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 0;

    logic [15:0] phy_word = 16'h786D;
    logic        bits [0:63];
    logic        oes  [0:63];
    int r = 0;
    int last_len = 0;
    int frames = 0;
    int chg_cnt = 0;

    always #5 clk = ~clk;

    mdio_autopoll dut (
        .clk(clk), .rst(rst), .poll_en(poll_en), .phy_present(phy_present),
        .phy_addr(phy_addr), .gap_sel(gap_sel), .use_alt_reg(use_alt_reg),
        .alt_reg_addr(alt_reg_addr), .mdio_i(mdio_i), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .frame_busy(frame_busy),
        .status_word(status_word), .status_valid(status_valid),
        .status_changed(status_changed), .link_down(link_down)
    );

    // PHY model: record what the MAC sends, answer in the data phase
    always @(posedge mdc) begin
        #1;
        if (frame_busy && r < 64) begin
            bits[r] = mdio_o;
            oes[r]  = mdio_oe;
            r++;
        end
    end

    always @(negedge mdc) begin
        #1;
        if (!frame_busy) begin
            if (r != 0) last_len = r;
            r = 0;
            mdio_i = 1'b1;
        end else if (r >= 48 && r < 64) begin
            mdio_i = phy_word[63 - r];
        end else begin
            mdio_i = 1'b1;
        end
    end

    always @(posedge frame_busy) frames++;
    always @(negedge clk) if (status_changed) chg_cnt++;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_frame_end();
        @(negedge frame_busy);
        #3;
    endtask

    task automatic check_header(input string req, input logic [4:0] pa, input logic [4:0] ra);
        logic [63:0] got, exp_bits, got_oe, exp_oe;
        exp_bits = {32'hFFFF_FFFF, 4'b0110, pa, ra, 18'h3FFFF};
        exp_oe   = {46'h3FFF_FFFF_FFFF, 18'h0};
        for (int i = 0; i < 64; i++) begin
            got[63 - i]    = bits[i];
            got_oe[63 - i] = oes[i];
        end
        check(got[63:18] == exp_bits[63:18], req, "frame header bits",
              got[63:32] ^ got[49:18], exp_bits[49:18]);
        check(got_oe == exp_oe, "R4", "output enable per bit", got_oe[31:0], exp_oe[31:0]);
        check(last_len == 64, req, "frame length", last_len, 64);
    endtask

    task automatic t_reset();
        check(mdc == 1'b0 && mdio_o == 1'b1 && mdio_oe == 1'b0, "R1", "pins after reset",
              {mdc, mdio_o, mdio_oe}, 3'b010);
        check(!frame_busy && !status_valid && !status_changed && !link_down, "R1",
              "flags after reset", {frame_busy, status_valid, status_changed, link_down}, 0);
    endtask

    task automatic t_mdc_period();
        realtime t0, t1, t2;
        @(posedge mdc); t0 = $realtime;
        @(negedge mdc); t1 = $realtime;
        @(posedge mdc); t2 = $realtime;
        check(int'((t1 - t0) / 10.0) == 2, "R2", "mdc high cycles", int'((t1 - t0) / 10.0), 2);
        check(int'((t2 - t0) / 10.0) == 4, "R2", "mdc period cycles", int'((t2 - t0) / 10.0), 4);
    endtask

    task automatic t_first_frame();
        @(negedge clk) poll_en = 1'b1;
        wait_frame_end();
        check_header("R3", 5'h13, 5'd1);
        check(bits[41] == 0 && bits[45] == 1, "R5", "default register 1", {bits[41], bits[45]}, 2'b01);
        check(status_word == 16'h786D && status_valid, "R6", "captured word",
              {status_valid, status_word}, {1'b1, 16'h786D});
        check(chg_cnt == 0, "R8", "no pulse on first capture", chg_cnt, 0);
        check(link_down == 1'b0, "R9", "link up on bit2=1", link_down, 0);
    endtask

    task automatic t_words();
        wait_frame_end();
        check(chg_cnt == 0, "R8", "no pulse on equal word", chg_cnt, 0);
        phy_word = 16'h7869;
        wait_frame_end();
        check(status_word == 16'h7869, "R6", "second word", status_word, 16'h7869);
        check(chg_cnt == 1, "R8", "pulse on changed word", chg_cnt, 1);
        check(link_down == 1'b1, "R9", "link down on bit2=0", link_down, 1);
        phy_word = 16'h786D;
        wait_frame_end();
        check(chg_cnt == 2, "R8", "pulse on restore", chg_cnt, 2);
        check(link_down == 1'b0, "R9", "link back up", link_down, 0);
    endtask

    task automatic t_alt_reg();
        use_alt_reg = 1'b1;
        alt_reg_addr = 5'h1E;
        phy_addr = 5'h05;
        wait_frame_end();
        check_header("R5", 5'h05, 5'h1E);
        use_alt_reg = 1'b0;
        phy_addr = 5'h13;
        wait_frame_end();
    endtask

    task automatic t_gap(input logic [2:0] sel);
        realtime t0;
        int got, g;
        g = (sel == 0) ? 0 : (1 << (sel + 4));
        gap_sel = sel;
        @(negedge frame_busy); t0 = $realtime;
        @(posedge frame_busy);
        got = int'(($realtime - t0) / 10.0);
        check(got == (g + 1) * 4, "R7", $sformatf("idle cycles sel=%0d", sel), got, (g + 1) * 4);
    endtask

    task automatic t_absent();
        int f0;
        wait_frame_end();
        phy_present = 1'b0;
        f0 = frames;
        repeat (800) @(negedge clk);
        check(frames == f0 && !frame_busy, "R10", "no frame without PHY", frames, f0);
        phy_present = 1'b1;
        repeat (20) @(negedge clk);
        check(frames == f0 + 1, "R10", "frame resumes with PHY", frames, f0 + 1);
    endtask

    task automatic t_cut_enable();
        int f0;
        @(posedge frame_busy);
        repeat (40) @(negedge clk);
        poll_en = 1'b0;
        wait_frame_end();
        check(last_len == 64, "R11", "frame completes after disable", last_len, 64);
        check(mdio_oe == 1'b0, "R4", "released after frame", mdio_oe, 0);
        f0 = frames;
        repeat (800) @(negedge clk);
        check(frames == f0, "R10", "no frame while disabled", frames, f0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mdc_period();
        t_first_frame();
        t_words();
        t_alt_reg();
        t_gap(3'd1);
        t_gap(3'd3);
        t_gap(3'd7);
        t_gap(3'd0);
        t_absent();
        t_cut_enable();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end
endmodule